// File: doc/BRIEF.md
# Free-running timer with coherent byte access

This block keeps a 16-bit up-counter that advances on every edge of its own timer clock, which is asynchronous to the CPU bus clock. Software sees the count through two byte-wide registers on an 8-bit bus.

Reading the low byte returns the low half and, in the same cycle, freezes the high half in a holding register. A later read of the high byte therefore returns a value taken at the same counter instant. Writes work the other way round. A low-byte write is only staged. The high-byte write then sends the full 16-bit value across to the timer domain, where it replaces the count.

Two interrupt pulses leave the block, each one bus-clock cycle long. The tick pulse fires each time the low twelve counter bits roll over through counting. The wrap pulse fires each time the whole counter rolls over.

Internally, the count is published to the bus domain through a toggle handshake that repeats continuously. The bus side therefore always holds a recent, internally consistent copy of the count. Load requests and interrupt events cross the boundary by the same toggle method.

Top module: `free_run_timer`

## Requirements
- R1: The counter advances by one on every rising edge of `tclk` and goes from 0xFFFF to 0x0000.
- R2: The low byte sits at offset 0x20 and the high byte at 0x21. Read data appears on `rdata` in the bus cycle after `rd_en`. In every cycle that does not follow a read of one of these two offsets, `rdata` is 0x00.
- R3: A low-byte read returns bits [7:0] of the bus-side copy of the count and stores bits [15:8] in a holding register. A following high-byte read returns the stored bits. The 16-bit value assembled this way trails the true count by at most 24 timer counts at the bench clock ratio.
- R4: Reading the high byte again, with no low-byte read in between, returns the same held value, even after the counter's high byte has moved on.
- R5: A low-byte write only stages its byte. On its own it does not change the count.
- R6: A high-byte write loads {written byte, staged low byte} into the counter, and counting continues from there. The staged byte remains available for later high-byte writes.
- R7: `irq_tick` pulses for exactly one bus cycle each time counting takes bits [11:0] from 0xFFF to 0x000.
- R8: `irq_wrap` pulses for exactly one bus cycle each time counting takes the counter from 0xFFFF to 0x0000.
- R9: A load never produces a tick or wrap pulse, including a load of a value whose low twelve bits are zero.
- R10: While `rst` is high and in the cycle after it, `rdata` is 0x00 and neither interrupt is raised. Reset clears the count, the holding register and the staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst | input | 1 | Synchronous reset, active high, in the bus clock domain; re-timed internally for the timer domain |
| tclk | input | 1 | Timer clock that drives the counter, asynchronous to `clk` |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr` and `wdata` |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data, 0x00 when no read is pending |
| irq_tick | output | 1 | One-cycle pulse on each 4096-count rollover |
| irq_wrap | output | 1 | One-cycle pulse on each full counter rollover |

## Verification
Read data is due exactly one bus cycle after the strobe, so the bench samples `rdata` at the falling edge that follows. In every other cycle it checks for 0x00.

Results that cross the clock boundary take a variable number of cycles: a counter load needs a few timer edges, and the published copy trails the counter by a few more. The bench therefore waits at least 60 bus cycles after a load before reading. It then accepts a value that trails its own counter model by no more than 24 counts.

Interrupt pulses arrive about three bus cycles after the timer-side event. The bench counts them on every cycle and compares the totals with the model only after a settling wait of hundreds of cycles. Loads are placed far from rollover points, so the short phase difference between model and design cannot alter those totals.

// File: rtl/frt_pkg.sv
package frt_pkg;

    // Which byte register an offset selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } frt_sel_e;

endpackage

// File: rtl/frt_sync_bit.sv
// Multi-stage synchronizer for one level signal (toggle carriers)
module frt_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/frt_core.sv
// Timer-clock domain: counter, load application, publishing, event toggles
module frt_core #(
    parameter int CNT_W       = 16,
    parameter int TICK_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             tclk,
    input  logic             rst,
    input  logic             ld_tog,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             pub_ack_tog,
    output logic             pub_tog,
    output logic [CNT_W-1:0] pub_val,
    output logic             tick_tog,
    output logic             wrap_tog
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pub_val;
        logic             pub_tog;
        logic             tick_tog;
        logic             wrap_tog;
        logic             ld_seen;
    } core_st_t;

    core_st_t  st_d, st_q;
    logic [1:0] trst_pipe_q;
    logic      trst;
    logic      ld_lvl;
    logic      ack_lvl;
    logic      ld_pulse;

    // Reset re-timed into the timer domain
    always_ff @(posedge tclk) begin
        trst_pipe_q <= {trst_pipe_q[0], rst};
    end
    assign trst = trst_pipe_q[1];

    frt_sync_bit #(.STAGES(SYNC_STAGES)) u_ld_sync (
        .clk (tclk),
        .rst (trst),
        .din (ld_tog),
        .dout(ld_lvl)
    );

    frt_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (tclk),
        .rst (trst),
        .din (pub_ack_tog),
        .dout(ack_lvl)
    );

    assign ld_pulse = ld_lvl ^ st_q.ld_seen;

    always_comb begin
        st_d         = st_q;
        st_d.ld_seen = ld_lvl;
        if (ld_pulse) begin
            // bus side holds ld_val stable since before its toggle moved
            st_d.cnt = ld_val;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt[TICK_W-1:0]) st_d.tick_tog = ~st_q.tick_tog;
            if (&st_q.cnt)             st_d.wrap_tog = ~st_q.wrap_tog;
        end
        // previous value acknowledged: publish a fresh one
        if (ack_lvl == st_q.pub_tog) begin
            st_d.pub_val = st_q.cnt;
            st_d.pub_tog = ~st_q.pub_tog;
        end
    end

    always_ff @(posedge tclk) begin
        if (trst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign pub_tog  = st_q.pub_tog;
    assign pub_val  = st_q.pub_val;
    assign tick_tog = st_q.tick_tog;
    assign wrap_tog = st_q.wrap_tog;

endmodule

// File: rtl/frt_bus_regs.sv
// Bus-clock domain: register decode, holding/staging, count copy, interrupts
module frt_bus_regs
    import frt_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO     = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_HI     = 8'h21,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                pub_tog,
    input  logic [2*DATA_W-1:0] pub_val,
    input  logic                tick_tog,
    input  logic                wrap_tog,
    output logic [DATA_W-1:0]   rdata,
    output logic                ld_tog,
    output logic [2*DATA_W-1:0] ld_val,
    output logic                ack_tog,
    output logic                irq_tick,
    output logic                irq_wrap
);

    localparam int CNT_W = 2 * DATA_W;
    localparam int N_EVT = 3;     // 0: publish, 1: tick, 2: wrap

    typedef struct packed {
        logic [CNT_W-1:0]  mirror;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] stage;
        logic [CNT_W-1:0]  ld_val;
        logic              ld_tog;
        logic              ack_tog;
        logic [N_EVT-1:0]  seen;
        logic [DATA_W-1:0] rdata;
        logic              irq_tick;
        logic              irq_wrap;
    } bus_st_t;

    bus_st_t          st_d, st_q;
    logic [N_EVT-1:0] evt_raw, evt_lvl, evt_pulse;
    frt_sel_e         sel;

    assign evt_raw = {wrap_tog, tick_tog, pub_tog};

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt_sync
        frt_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (evt_raw[i]),
            .dout(evt_lvl[i])
        );
    end

    assign evt_pulse = evt_lvl ^ st_q.seen;

    function automatic frt_sel_e decode(input logic [ADDR_W-1:0] a);
        if (a == ADDR_LO) return SEL_LO;
        if (a == ADDR_HI) return SEL_HI;
        return SEL_NONE;
    endfunction

    assign sel = decode(addr);

    always_comb begin
        st_d          = st_q;
        st_d.seen     = evt_lvl;
        st_d.rdata    = '0;
        st_d.irq_tick = evt_pulse[1];
        st_d.irq_wrap = evt_pulse[2];

        // published value is stable while its toggle is in flight
        if (evt_pulse[0]) begin
            st_d.mirror  = pub_val;
            st_d.ack_tog = evt_lvl[0];
        end

        if (rd_en) begin
            case (sel)
                SEL_LO: begin
                    st_d.rdata = st_q.mirror[DATA_W-1:0];
                    st_d.hold  = st_q.mirror[CNT_W-1:DATA_W];
                end
                SEL_HI:  st_d.rdata = st_q.hold;
                default: ;
            endcase
        end

        if (wr_en) begin
            case (sel)
                SEL_LO: st_d.stage = wdata;
                SEL_HI: begin
                    st_d.ld_val = {wdata, st_q.stage};
                    st_d.ld_tog = ~st_q.ld_tog;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata    = st_q.rdata;
    assign ld_tog   = st_q.ld_tog;
    assign ld_val   = st_q.ld_val;
    assign ack_tog  = st_q.ack_tog;
    assign irq_tick = st_q.irq_tick;
    assign irq_wrap = st_q.irq_wrap;

endmodule

// File: rtl/free_run_timer.sv
module free_run_timer #(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO     = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_HI     = 8'h21,
    parameter int                TICK_W      = 12,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tclk,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_tick,
    output logic              irq_wrap
);

    localparam int CNT_W = 2 * DATA_W;

    logic             ld_tog, ack_tog, pub_tog, tick_tog, wrap_tog;
    logic [CNT_W-1:0] ld_val, pub_val;

    frt_core #(
        .CNT_W      (CNT_W),
        .TICK_W     (TICK_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_core (
        .tclk       (tclk),
        .rst        (rst),
        .ld_tog     (ld_tog),
        .ld_val     (ld_val),
        .pub_ack_tog(ack_tog),
        .pub_tog    (pub_tog),
        .pub_val    (pub_val),
        .tick_tog   (tick_tog),
        .wrap_tog   (wrap_tog)
    );

    frt_bus_regs #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .ADDR_LO    (ADDR_LO),
        .ADDR_HI    (ADDR_HI),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_bus (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .pub_tog (pub_tog),
        .pub_val (pub_val),
        .tick_tog(tick_tog),
        .wrap_tog(wrap_tog),
        .rdata   (rdata),
        .ld_tog  (ld_tog),
        .ld_val  (ld_val),
        .ack_tog (ack_tog),
        .irq_tick(irq_tick),
        .irq_wrap(irq_wrap)
    );

endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
    parameter int                DATA_W  = 8,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_HI = 8'h21
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              irq_tick,
    input logic              irq_wrap
);

    p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq_tick |=> !irq_tick);

    p_wrap_single_r8: assert property (@(posedge clk) disable iff (rst)
        irq_wrap |=> !irq_wrap);

    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && (addr == ADDR_LO || addr == ADDR_HI)) |=> (rdata == '0));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (rdata == '0 && !irq_tick && !irq_wrap));

endmodule

bind free_run_timer frt_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .ADDR_LO(ADDR_LO),
    .ADDR_HI(ADDR_HI)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .irq_tick(irq_tick),
    .irq_wrap(irq_wrap)
);

// File: tb/sim_free_run_timer.sv
module sim_free_run_timer;

    localparam int CLK_PERIOD  = 10;
    localparam int TCLK_PERIOD = 34;
    localparam int LAG_MAX     = 24;
    localparam int WATCHDOG    = 150000;

    logic       clk = 1'b0, tclk = 1'b0, rst = 1'b1;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_tick, irq_wrap;

    free_run_timer u0 (
        .clk(clk), .rst(rst), .tclk(tclk), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_tick(irq_tick), .irq_wrap(irq_wrap)
    );

    always #(CLK_PERIOD/2)  clk  = ~clk;
    always #(TCLK_PERIOD/2) tclk = ~tclk;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // ---------------- behavioural reference model ----------------
    logic [15:0] model_cnt = 16'h0000;
    bit          load_pend = 0;
    logic [15:0] load_word = 16'h0000;
    int          exp_tick = 0, exp_wrap = 0;

    always @(posedge tclk) begin
        if (rst) begin
            model_cnt = 16'h0000;
            load_pend = 0;
        end else if (load_pend) begin
            model_cnt = load_word;
            load_pend = 0;
        end else begin
            if (model_cnt[11:0] == 12'hFFF) exp_tick++;
            if (model_cnt == 16'hFFFF)      exp_wrap++;
            model_cnt = model_cnt + 16'd1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- per-clock comparison ----------------
    bit rd_seen = 0;
    bit tick_prev = 0, wrap_prev = 0;
    int got_tick = 0, got_wrap = 0;

    always @(posedge clk) rd_seen <= rd_en && (addr == 8'h20 || addr == 8'h21);

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (!rd_seen) check(rdata == 8'h00, "R2", "idle rdata", rdata, 0);
            if (irq_tick && tick_prev) check(0, "R7", "tick pulse longer than one cycle", 1, 0);
            if (irq_wrap && wrap_prev) check(0, "R8", "wrap pulse longer than one cycle", 1, 0);
            if (irq_tick) got_tick++;
            if (irq_wrap) got_wrap++;
        end
        tick_prev = irq_tick;
        wrap_prev = irq_wrap;
    end

    // ---------------- bus tasks ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0; addr = 8'h00;
        d = rdata;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input bit is_load,
                             input logic [15:0] full);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        if (is_load) begin
            load_word = full;
            load_pend = 1;
        end
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
    endtask

    task automatic load16(input logic [15:0] v);
        bus_write(8'h20, v[7:0], 0, 16'h0);
        bus_write(8'h21, v[15:8], 1, v);
    endtask

    function automatic bit in_window(input logic [15:0] model_v, input logic [15:0] got);
        logic [15:0] diff;
        diff = model_v - got;
        return diff <= LAG_MAX;
    endfunction

    task automatic read16(output logic [15:0] v, output logic [15:0] m);
        logic [7:0] lo, hi;
        @(negedge clk);
        m = model_cnt;
        bus_read(8'h20, lo);
        bus_read(8'h21, hi);
        v = {hi, lo};
    endtask

    task automatic check_irqs(input string req);
        check(got_tick == exp_tick, req, "tick pulse total", got_tick, exp_tick);
        check(got_wrap == exp_wrap, req, "wrap pulse total", got_wrap, exp_wrap);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] v, m;
        logic [7:0]  b, lo, hi;
        int          t0, w0;

        idle(8);
        // R10: outputs quiet during reset
        check(rdata == 8'h00, "R10", "rdata in reset", rdata, 0);
        check(!irq_tick && !irq_wrap, "R10", "irq in reset", {irq_tick, irq_wrap}, 0);
        rst = 1'b0;
        idle(2);
        check(rdata == 8'h00, "R10", "rdata after reset", rdata, 0);
        // R10: high byte held value starts at zero
        bus_read(8'h21, b);
        check(b == 8'h00, "R10", "hold after reset", b, 0);

        // R1 / R3: free-running from zero
        idle(100);
        read16(v, m);
        check(in_window(m, v), "R1", "count after reset", v, m);

        // R2: unmapped offset reads as zero
        bus_read(8'h22, b);
        check(b == 8'h00, "R2", "unmapped read", b, 0);

        // R5: staged low byte alone changes nothing
        bus_write(8'h20, 8'hAB, 0, 16'h0);
        idle(100);
        read16(v, m);
        check(in_window(m, v), "R5", "count after low-only write", v, m);

        // R6: full load
        load16(16'h1234);
        idle(100);
        read16(v, m);
        check(in_window(m, v), "R6", "count after load 0x1234", v, m);

        // R6: high-only write reuses the staged low byte
        idle(20);
        bus_write(8'h21, 8'h40, 1, 16'h4034);
        idle(100);
        read16(v, m);
        check(in_window(m, v), "R6", "count after high-only write", v, m);

        // R3 / R4: coherent read across a high-byte change
        load16(16'h12E8);
        idle(60);
        @(negedge clk);
        m = model_cnt;
        bus_read(8'h20, lo);
        idle(200);
        bus_read(8'h21, hi);
        check(hi == 8'h12, "R3", "held high byte", hi, 8'h12);
        check(in_window(m, {hi, lo}), "R3", "coherent value", {hi, lo}, m);
        bus_read(8'h21, b);
        check(b == 8'h12, "R4", "repeated high read", b, 8'h12);
        read16(v, m);
        check(v[15:8] == 8'h13, "R3", "fresh high byte", v[15:8], 8'h13);
        check(in_window(m, v), "R3", "fresh value", v, m);

        // R8 / R7 / R1: wrap through 0xFFFF
        check_irqs("R10");
        t0 = got_tick; w0 = got_wrap;
        load16(16'hFFF0);
        idle(300);
        check(got_wrap == w0 + 1, "R8", "one wrap pulse", got_wrap, w0 + 1);
        check(got_tick == t0 + 1, "R7", "tick at full wrap", got_tick, t0 + 1);
        check_irqs("R8");
        read16(v, m);
        check(in_window(m, v), "R1", "count after wrap", v, m);

        // R7: tick without wrap
        t0 = got_tick; w0 = got_wrap;
        load16(16'h0FF0);
        idle(300);
        check(got_tick == t0 + 1, "R7", "tick at 0x1000", got_tick, t0 + 1);
        check(got_wrap == w0, "R7", "no wrap at 0x1000", got_wrap, w0);

        // R7: natural tick after a longer run
        t0 = got_tick;
        load16(16'h0F00);
        idle(1200);
        check(got_tick == t0 + 1, "R7", "tick after long run", got_tick, t0 + 1);
        check_irqs("R7");

        // R9: loads do not raise events
        t0 = got_tick; w0 = got_wrap;
        load16(16'h5000);
        idle(100);
        load16(16'h0000);
        idle(100);
        load16(16'h1000);
        idle(100);
        check(got_tick == t0, "R9", "tick after loads", got_tick, t0);
        check(got_wrap == w0, "R9", "wrap after loads", got_wrap, w0);
        read16(v, m);
        check(in_window(m, v), "R9", "count after load 0x1000", v, m);
        check_irqs("R9");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule